// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block steps through a 128-word program store. Each word carries an opcode, two address fields, a count field and a group of user control bits. The user control bits of the word at the current program counter drive the control output directly. There is no arithmetic unit. Flow control comes from a range counter and a frame stack. A FOR word or a CALL word opens a frame that names a first address, a last address and a number of passes. When the frame's last address executes sequentially, the sequencer jumps back to the first address or resumes at the saved return address in the same cycle, so there is no branch penalty and no return word. A conditional branch word tests one of the condition inputs and jumps when it is high.

The program image is a parameter of the top module. A datapath driven by the control bits sits outside the block.

Top module: `loopseq_top`

## Requirements
- R1: Reset sets the program counter to 0, empties the frame stack and clears `halted_o` and `overflow_o`. While reset is high, `ctrl_o` shows the control field of word 0.
- R2: Each program word is laid out as opcode [35:33], field A [32:26], field B [25:19], count [18:11] and user control [10:0]. `ctrl_o` always equals bits [10:0] of the word at the current program counter.
- R3: A FOR word (opcode 1) with count n>0 runs addresses A..B n times back to back. No idle cycle occurs between passes. Execution then continues at B+1 in the cycle after the last pass ends.
- R4: A FOR word with count 0 skips its body and continues at B+1 in the next cycle.
- R5: A CALL word (opcode 2) runs addresses A..B once and then resumes at the CALL address + 1 in the next cycle. No return word is needed. A single-word section (A = B) is allowed.
- R6: Frames nest. The end-of-range test uses only the innermost frame, so an inner loop completes all of its passes inside each pass of the outer loop.
- R7: A BRANCH word (opcode 3) jumps to A when the condition input selected by count bits [13:11] is high. Otherwise it acts as a plain step. A branch to its own address waits for the input to fall.
- R8: A HALT word (opcode 4) freezes the program counter. `halted_o` rises in the next cycle and stays high until reset.
- R9: A FOR or CALL issued while the stack already holds STACK_DEPTH frames pushes nothing and freezes the program counter. `overflow_o` and `halted_o` rise in the next cycle.
- R10: Opcodes 0, 5, 6 and 7 are plain steps: the program counter moves to the next address, or to the innermost frame's loop-back or return address when the current address is that frame's B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | COND_N | Branch condition inputs |
| ctrl_o | output | 11 | User control bits of the current word |
| halted_o | output | 1 | Sequencer stopped by HALT or by overflow |
| overflow_o | output | 1 | A push was refused because the stack was full |

## Verification
Two functions can fall in the same cycle. In one case the innermost frame's last address is reached while an enclosing frame is still counting. In the other case a frame opens while the stack is full. The program has nested loops whose ends lie one word apart, a single-word subroutine and a self-calling word that fills a four-frame stack. The bench repeats the run for several lengths of a condition wait, resetting between runs, and compares every cycle's control output and flags against a cycle sequence it derives from the requirements. This shows that loop-back, pop and overflow land in exactly the predicted cycles.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;

    localparam int ADDR_W    = 7;
    localparam int CNT_W     = 8;
    localparam int OP_W      = 3;
    localparam int SEL_W     = 3;
    localparam int WORD_W    = 36;
    localparam int CTRL_W    = WORD_W - OP_W - 2 * ADDR_W - CNT_W;
    localparam int ROM_WORDS = 1 << ADDR_W;

    localparam logic [OP_W-1:0] OP_STEP   = 3'd0;
    localparam logic [OP_W-1:0] OP_FOR    = 3'd1;
    localparam logic [OP_W-1:0] OP_CALL   = 3'd2;
    localparam logic [OP_W-1:0] OP_BRANCH = 3'd3;
    localparam logic [OP_W-1:0] OP_HALT   = 3'd4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        addr_t             fa;
        addr_t             fb;
        cnt_t              cnt;
        logic [CTRL_W-1:0] ctrl;
    } instr_t;

    typedef struct packed {
        addr_t ret;
        addr_t first;
        addr_t last;
        cnt_t  left;
    } frame_t;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_DEC
    } stk_op_e;

    function automatic instr_t make_instr(logic [OP_W-1:0] op, int a, int b,
                                          int c, int ctrl);
        instr_t w;
        w.op   = op;
        w.fa   = addr_t'(a);
        w.fb   = addr_t'(b);
        w.cnt  = cnt_t'(c);
        w.ctrl = CTRL_W'(ctrl);
        return w;
    endfunction

endpackage

// File: rtl/loopseq_rom.sv
module loopseq_rom
    import loopseq_pkg::*;
#(
    parameter logic [ROM_WORDS*WORD_W-1:0] INIT = '0
) (
    input  addr_t  addr,
    output instr_t word
);

    instr_t mem [ROM_WORDS];

    for (genvar g = 0; g < ROM_WORDS; g++) begin : g_word
        assign mem[g] = instr_t'(INIT[g*WORD_W +: WORD_W]);
    end

    assign word = mem[addr];

endmodule

// File: rtl/loopseq_stack.sv
module loopseq_stack
    import loopseq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  stk_op_e         op,
    input  frame_t          push_frame,
    output frame_t          top,
    output logic            empty,
    output logic            full,
    output logic [SP_W-1:0] sp
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t            mem [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   sp_m1;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign sp_m1   = sp_q - 1'b1;
    assign top_idx = sp_m1[IDX_W-1:0];
    assign wr_idx  = sp_q[IDX_W-1:0];
    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SP_W'(DEPTH));
    assign top     = mem[top_idx];
    assign sp      = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else begin
            case (op)
                STK_PUSH: if (!full)  sp_q <= sp_q + 1'b1;
                STK_POP:  if (!empty) sp_q <= sp_m1;
                default:  sp_q <= sp_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (op == STK_PUSH && !full) begin
                mem[wr_idx] <= push_frame;
            end else if (op == STK_DEC && !empty) begin
                mem[top_idx].left <= top.left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/loopseq_nextpc.sv
module loopseq_nextpc
    import loopseq_pkg::*;
#(
    parameter int COND_N = 4
) (
    input  addr_t             pc,
    input  instr_t            ins,
    input  logic [COND_N-1:0] cond,
    input  frame_t            top,
    input  logic              empty,
    input  logic              full,
    input  logic              halted,
    output addr_t             pc_nxt,
    output stk_op_e           sop,
    output frame_t            nf,
    output logic              halt_set,
    output logic              ovf_set
);

    localparam int CW = 1 << SEL_W;

    logic [CW-1:0] cond_ext;
    logic          cond_hit;
    logic          at_end;
    addr_t         pc_inc;
    addr_t         seq_pc;
    stk_op_e       seq_op;

    assign cond_ext = CW'(cond);
    assign cond_hit = cond_ext[ins.cnt[SEL_W-1:0]];
    assign at_end   = !empty && (pc == top.last);
    assign pc_inc   = pc + 1'b1;

    // sequential successor: loop back, pop to return, or plain increment
    always_comb begin
        seq_pc = pc_inc;
        seq_op = STK_HOLD;
        if (at_end) begin
            if (top.left != '0) begin
                seq_pc = top.first;
                seq_op = STK_DEC;
            end else begin
                seq_pc = top.ret;
                seq_op = STK_POP;
            end
        end
    end

    always_comb begin
        pc_nxt   = pc;
        sop      = STK_HOLD;
        halt_set = 1'b0;
        ovf_set  = 1'b0;
        nf.first = ins.fa;
        nf.last  = ins.fb;
        nf.ret   = (ins.op == OP_FOR) ? ins.fb + 1'b1 : pc_inc;
        nf.left  = (ins.op == OP_FOR) ? ins.cnt - 1'b1 : '0;
        if (!halted) begin
            case (ins.op)
                OP_HALT: begin
                    halt_set = 1'b1;
                end
                OP_FOR, OP_CALL: begin
                    if (ins.op == OP_FOR && ins.cnt == '0) begin
                        pc_nxt = ins.fb + 1'b1;
                    end else if (full) begin
                        ovf_set  = 1'b1;
                        halt_set = 1'b1;
                    end else begin
                        sop    = STK_PUSH;
                        pc_nxt = ins.fa;
                    end
                end
                OP_BRANCH: begin
                    if (cond_hit) begin
                        pc_nxt = ins.fa;
                    end else begin
                        pc_nxt = seq_pc;
                        sop    = seq_op;
                    end
                end
                default: begin
                    pc_nxt = seq_pc;
                    sop    = seq_op;
                end
            endcase
        end
    end

endmodule

// File: rtl/loopseq_top.sv
module loopseq_top
    import loopseq_pkg::*;
#(
    parameter int STACK_DEPTH = 128,
    parameter int COND_N      = 4,
    parameter logic [ROM_WORDS*WORD_W-1:0] ROM_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_N-1:0] cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              halted_o,
    output logic              overflow_o
);

    localparam int SP_W = $clog2(STACK_DEPTH + 1);

    addr_t           pc_q;
    addr_t           pc_nxt;
    instr_t          ins;
    frame_t          stk_top;
    frame_t          new_frame;
    stk_op_e         stk_op;
    logic            stk_empty;
    logic            stk_full;
    logic [SP_W-1:0] stk_sp;
    logic            halted_q;
    logic            ovf_q;
    logic            halt_set;
    logic            ovf_set;

    loopseq_rom #(.INIT(ROM_INIT)) u_rom (
        .addr (pc_q),
        .word (ins)
    );

    loopseq_stack #(.DEPTH(STACK_DEPTH), .SP_W(SP_W)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .op         (stk_op),
        .push_frame (new_frame),
        .top        (stk_top),
        .empty      (stk_empty),
        .full       (stk_full),
        .sp         (stk_sp)
    );

    loopseq_nextpc #(.COND_N(COND_N)) u_next (
        .pc       (pc_q),
        .ins      (ins),
        .cond     (cond_i),
        .top      (stk_top),
        .empty    (stk_empty),
        .full     (stk_full),
        .halted   (halted_q),
        .pc_nxt   (pc_nxt),
        .sop      (stk_op),
        .nf       (new_frame),
        .halt_set (halt_set),
        .ovf_set  (ovf_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            pc_q <= pc_nxt;
            if (halt_set) halted_q <= 1'b1;
            if (ovf_set)  ovf_q    <= 1'b1;
        end
    end

    assign ctrl_o     = ins.ctrl;
    assign halted_o   = halted_q;
    assign overflow_o = ovf_q;

endmodule

// File: rtl/loopseq_checker.sv
module loopseq_checker
    import loopseq_pkg::*;
#(
    parameter int STACK_DEPTH = 128,
    parameter int SP_W        = $clog2(STACK_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input addr_t           pc,
    input logic [SP_W-1:0] sp,
    input logic            halted,
    input logic            overflow
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && sp == '0 && !halted && !overflow));

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(sp)));

    assert_ovf_full_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(sp) == SP_W'(STACK_DEPTH)));

    assert_ovf_halts_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |-> halted);

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(STACK_DEPTH));

    assert_one_frame_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sp == $past(sp)) || (sp == $past(sp) + 1'b1) || (sp + 1'b1 == $past(sp)));

endmodule

bind loopseq_top loopseq_checker #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_q),
    .sp       (stk_sp),
    .halted   (halted_o),
    .overflow (overflow_o)
);

// File: tb/loopseq_top_test.sv
module loopseq_top_test;
    import loopseq_pkg::*;

    localparam int DEPTH  = 4;
    localparam int COND_N = 2;
    localparam int NSAMP  = 64;

    function automatic logic [ROM_WORDS*WORD_W-1:0] build_rom();
        logic [ROM_WORDS*WORD_W-1:0] r;
        for (int i = 0; i < ROM_WORDS; i++)
            r[i*WORD_W +: WORD_W] = make_instr(OP_STEP, 0, 0, 0, i);
        r[0*WORD_W  +: WORD_W] = make_instr(3'd7,      0,  0,  0, 0);
        r[1*WORD_W  +: WORD_W] = make_instr(OP_FOR,    2,  4,  3, 1);
        r[5*WORD_W  +: WORD_W] = make_instr(OP_FOR,    6,  6,  0, 5);
        r[7*WORD_W  +: WORD_W] = make_instr(OP_CALL,  20, 22,  0, 7);
        r[8*WORD_W  +: WORD_W] = make_instr(OP_FOR,    9, 12,  2, 8);
        r[9*WORD_W  +: WORD_W] = make_instr(OP_FOR,   10, 11,  2, 9);
        r[13*WORD_W +: WORD_W] = make_instr(OP_BRANCH, 13, 0,  0, 13);
        r[14*WORD_W +: WORD_W] = make_instr(OP_BRANCH, 50, 0,  1, 14);
        r[15*WORD_W +: WORD_W] = make_instr(OP_CALL,  30, 30,  0, 15);
        r[16*WORD_W +: WORD_W] = make_instr(OP_CALL,  40, 40,  0, 16);
        r[40*WORD_W +: WORD_W] = make_instr(OP_CALL,  40, 40,  0, 40);
        r[50*WORD_W +: WORD_W] = make_instr(OP_HALT,   0,  0,  0, 50);
        return r;
    endfunction

    localparam logic [ROM_WORDS*WORD_W-1:0] PROG = build_rom();

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [COND_N-1:0] cond = '0;
    logic [CTRL_W-1:0] ctrl;
    logic              halted;
    logic              overflow;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    int    exp_pc  [NSAMP];
    string exp_tag [NSAMP];
    int    n_exp;

    always #10 clk = ~clk;

    loopseq_top #(.STACK_DEPTH(DEPTH), .COND_N(COND_N), .ROM_INIT(PROG)) uut (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond),
        .ctrl_o     (ctrl),
        .halted_o   (halted),
        .overflow_o (overflow)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic add(int v, string t);
        if (n_exp < NSAMP) begin
            exp_pc[n_exp]  = v;
            exp_tag[n_exp] = t;
            n_exp++;
        end
    endtask

    // expected address trace built from the requirements
    task automatic build_exp(int hold, bit take_halt);
        n_exp = 0;
        add(0, "R1"); add(1, "R10");
        for (int p = 0; p < 3; p++) begin
            add(2, "R3"); add(3, "R3"); add(4, "R3");
        end
        add(5, "R3"); add(7, "R4");
        add(20, "R5"); add(21, "R5"); add(22, "R5"); add(8, "R5");
        for (int o = 0; o < 2; o++) begin
            add(9, "R6");
            for (int q = 0; q < 2; q++) begin
                add(10, "R6"); add(11, "R6");
            end
            add(12, "R6");
        end
        if (!take_halt) begin
            for (int h = 0; h <= hold; h++) add(13, "R7");
            add(14, "R7"); add(15, "R5"); add(30, "R5"); add(16, "R5");
            while (n_exp < NSAMP) add(40, "R9");
        end else begin
            add(13, "R7"); add(14, "R7");
            while (n_exp < NSAMP) add(50, "R8");
        end
    endtask

    task automatic run(int hold, bit take_halt);
        build_exp(hold, take_halt);
        @(negedge clk);
        rst  = 1'b1;
        cond = '0;
        repeat (3) @(negedge clk);
        check("R1 reset ctrl", int'(ctrl), 0);
        check("R1 reset halted", int'(halted), 0);
        check("R1 reset overflow", int'(overflow), 0);
        rst = 1'b0;
        for (int i = 0; i < NSAMP; i++) begin
            cond[0] = (i < 29 + hold) && !take_halt;
            cond[1] = take_halt;
            check({exp_tag[i], " R2 ctrl"}, int'(ctrl), exp_pc[i]);
            if (take_halt) begin
                check("R8 halted", int'(halted), (i >= 32) ? 1 : 0);
                check("R8 overflow", int'(overflow), 0);
            end else begin
                check("R9 overflow", int'(overflow), (i >= 38 + hold) ? 1 : 0);
                check("R9 halted", int'(halted), (i >= 38 + hold) ? 1 : 0);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int h = 0; h < 5; h++) run(h, 1'b0);
        run(0, 1'b1);
        run(2, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule